// File: doc/BRIEF.md
# Two-Bit Counter Branch Direction Predictor

This block predicts branch direction at fetch time from a table of 2-bit saturating counters. The fetch PC selects one counter, and the block drives its most significant bit as a taken / not-taken guess in the same cycle. The PC's byte-offset bits are not used in the selection. The table has no tags, so PCs that differ only above the index bits share a counter.

A separate update port receives each resolved branch from the execute stage. It carries the branch PC and the real outcome, and it moves the selected counter one step toward that outcome, stopping at either end of the counter's range. Reads happen at fetch and writes happen only when a branch resolves, so the two ports work independently. Because the counter has two states on each side of the decision point, one surprising outcome does not change the prediction. Two in a row in the same direction do.

Top module: `bht_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), so every fetch PC predicts not-taken (pred_taken_o = 0).
- R2: Counter encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. pred_taken_o is bit 1 of the counter selected by fetch_pc_i, combinationally in the same cycle.
- R3: The table index is PC bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). Bits [1:0] and all bits above the index have no effect on either port.
- R4: An update with upd_taken_i = 1 increments the selected counter by one and leaves it at 11 if it already holds 11.
- R5: An update with upd_taken_i = 0 decrements the selected counter by one and leaves it at 00 if it already holds 00.
- R6: From a strong state, one opposite outcome does not change the prediction. A second consecutive opposite outcome does.
- R7: A counter changes only on a clock edge where upd_valid_i = 1 and upd_pc_i selects it. All other counters, and all counters when upd_valid_i = 0, keep their values.
- R8: When a fetch and an update select the same counter in one cycle, the prediction shows the value from before the update. The new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | PC_W | PC being fetched |
| pred_taken_o | output | 1 | Predicted direction for fetch_pc_i (1 = taken) |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome (1 = taken) |

## Verification
A corrupted counter is visible at the ports only through its top bit. A counter that is wrong in the low bit therefore stays hidden until outcomes push it across the taken/not-taken boundary, one or two updates later than the correct counter would cross. For this reason the bench tracks every counter's full 2-bit value in a model. After each update it reads back the prediction of every table entry through the fetch port. A wrong step, a missed saturation or a write to the wrong entry then shows up within the few updates needed to reach the boundary. Saturation and hysteresis are also probed with directed walks that count exactly how many opposite outcomes are needed to flip the prediction.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;
endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 12
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = pc_i[IDX_W+1:2];

  // offset and alias bits are dropped on purpose
  logic unused_lo;
  assign unused_lo = ^pc_i[1:0];

  if (PC_W > IDX_W + 2) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^pc_i[PC_W-1:IDX_W+2];
  end
endmodule

// File: rtl/bht_ctr_sat.sv
module bht_ctr_sat
  import bht_pkg::*;
(
  input  ctr_t ctr_i,
  input  logic taken_i,
  output ctr_t ctr_o
);
  always_comb begin
    ctr_o = ctr_i;
    if (taken_i) begin
      if (ctr_i != CTR_ST) ctr_o = ctr_t'(ctr_i + 2'd1);
    end else begin
      if (ctr_i != CTR_SNT) ctr_o = ctr_t'(ctr_i - 2'd1);
    end
  end
endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int ENTRIES = 4096,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ridx_i,
  output ctr_t             rdata_o,
  input  logic [IDX_W-1:0] widx_i,
  output ctr_t             wold_o,
  input  logic             we_i,
  input  ctr_t             wdata_i
);
  ctr_t mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= CTR_WNT;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
  assign wold_o  = mem_q[widx_i];
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int ENTRIES = 4096,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  logic [IDX_W-1:0] fidx, uidx;
  ctr_t fetch_ctr, upd_ctr, upd_next;

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) fetch_idx_i (.pc_i(fetch_pc_i), .idx_o(fidx));
  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) upd_idx_i   (.pc_i(upd_pc_i),   .idx_o(uidx));

  bht_ctr_sat sat_i (.ctr_i(upd_ctr), .taken_i(upd_taken_i), .ctr_o(upd_next));

  bht_table #(.ENTRIES(ENTRIES)) table_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ridx_i  (fidx),
    .rdata_o (fetch_ctr),
    .widx_i  (uidx),
    .wold_o  (upd_ctr),
    .we_i    (upd_valid_i),
    .wdata_i (upd_next)
  );

  assign pred_taken_o = fetch_ctr[1];

  // R4
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i && upd_ctr == CTR_ST
    |=> (uidx != $past(uidx)) || upd_ctr == CTR_ST);

  // R5
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i && upd_ctr == CTR_SNT
    |=> (uidx != $past(uidx)) || upd_ctr == CTR_SNT);

  // R4
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i && upd_ctr != CTR_ST
    |=> (uidx != $past(uidx)) || upd_ctr == ctr_t'($past(upd_ctr) + 2'd1));

  // R7
  no_upd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (fidx != $past(fidx)) || $stable(pred_taken_o));
endmodule

// File: tb/bht_predictor_tb_top.sv
module bht_predictor_tb_top;
  localparam int ENTRIES = 16;
  localparam int PC_W    = 12;
  localparam int IDX_W   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  int mdl [ENTRIES];
  bit done = 0;

  always #4 clk = ~clk;

  bht_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc), .pred_taken_o(pred),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  function automatic logic [PC_W-1:0] mk_pc(int idx, int lo, int hi);
    return PC_W'((hi << (IDX_W + 2)) | (idx << 2) | (lo & 3));
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  // fetch at negedge, sample 1 ns later
  task automatic probe(string req, int idx, int lo, int hi);
    fetch_pc = mk_pc(idx, lo, hi);
    #1;
    check(req, pred, mdl[idx] >= 2 ? 1'b1 : 1'b0);
  endtask

  task automatic update(int idx, bit taken, int lo, int hi);
    upd_valid = 1'b1;
    upd_pc    = mk_pc(idx, lo, hi);
    upd_taken = taken;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    if (taken) begin
      if (mdl[idx] < 3) mdl[idx]++;
    end else begin
      if (mdl[idx] > 0) mdl[idx]--;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) mdl[i] = 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, every entry
    for (int i = 0; i < ENTRIES; i++) probe("R1", i, i, i);

    // R2 R6 R4 directed walk on entry 5
    update(5, 1, 0, 0);
    probe("R2", 5, 0, 0);
    for (int k = 0; k < 4; k++) update(5, 1, k, 0);
    probe("R4", 5, 0, 0);
    update(5, 0, 1, 0);
    probe("R6", 5, 3, 0);
    update(5, 0, 2, 0);
    probe("R6", 5, 0, 0);
    // R5 saturate low, then one taken must not flip
    for (int k = 0; k < 5; k++) update(5, 0, 0, 3);
    update(5, 1, 0, 0);
    probe("R5", 5, 0, 0);
    update(5, 1, 0, 0);
    probe("R5", 5, 0, 0);

    // R8 same-cycle read of the entry being updated
    upd_valid = 1'b1;
    upd_pc    = mk_pc(3, 2, 1);
    upd_taken = 1'b1;
    fetch_pc  = mk_pc(3, 1, 0);
    #1;
    check("R8", pred, 1'b0);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    mdl[3] = 2;
    #1;
    check("R8", pred, 1'b1);

    // R7 idle cycles leave all entries unchanged
    upd_pc = mk_pc(9, 0, 0);
    upd_taken = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < ENTRIES; i++) probe("R7", i, 0, 2);

    // R3 R7 sweep: varying offset and alias bits, full table read-back
    for (int s = 0; s < 240; s++) begin
      int idx = (s * 7 + s / 16) % ENTRIES;
      bit tk  = ((s * 5 + s / 3) % 4) < 2;
      update(idx, tk, s % 4, (s / 4) % 4);
      for (int i = 0; i < ENTRIES; i++) probe("R3", i, (s + i) % 4, (s + i) % 4);
    end

    finish_run();
  end
endmodule